// File: doc/BRIEF.md
# Packed Subword Saturating ALU

This block is a one-stage packed-integer datapath. It takes two 64-bit operands and splits each into eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. It applies the same operation to every lane at once. Carries and borrows never cross a lane boundary, and an overflow inside a lane is resolved in that lane alone, either by wrapping or by clamping. No trap is ever raised.

The opcode selects four things: the lane size, the function, a signed/unsigned mode bit and a 2-bit shift amount. The functions are:
- add and subtract, each with wrap-around or with saturation;
- a shift-then-add that scales the second operand by a power of two;
- equality and greater-than compares that write full-lane masks;
- the bitwise operations needed to build a select from such a mask.

The result is registered when the input valid is high. Two flags travel with it: one says the whole result is all ones, the other says it is all zeros. Software uses these flags as the "every lane true" and "no lane true" summary of a compare.

Top module: `simd_sat_alu`

## Requirements
- R1: Opcode layout: bits [1:0] select the lane size (0 = 8-bit, 1 = 16-bit, 2 = 32-bit), bits [5:2] the function, bit 6 the signed mode, and bits [8:7] a shift amount of 0 to 3. Lane 0 occupies the least significant bits.
- R2: Function 0 (add) and function 2 (subtract) wrap modulo the lane width, and no carry or borrow reaches a neighbouring lane. Example: 0x1A00 + 0xF700 in a 16-bit lane gives 0x1100.
- R3: In unsigned mode (bit 6 = 0), function 1 (saturating add) clamps to the lane's all-ones value and function 3 (saturating subtract) clamps to 0. Examples: 0x1A00 + 0xF700 gives 0xFFFF in a 16-bit lane; in 8-bit lanes, 40 − 51 gives 0 and 78 − 15 gives 63.
- R4: In signed mode (bit 6 = 1), functions 1 and 3 clamp to 0x7F, 0x7FFF or 0x7FFFFFFF on positive overflow, and to 0x80, 0x8000 or 0x80000000 on negative overflow.
- R5: Function 4 adds operand A to operand B shifted right by the shift amount in each lane, wrapping. The shift is logical in unsigned mode and arithmetic in signed mode.
- R6: Function 5 writes all ones to each lane where A equals B and all zeros to every other lane.
- R7: Function 6 writes all ones to each lane where A is greater than B and all zeros to every other lane. The comparison is signed or unsigned according to bit 6.
- R8: Function 7 gives A AND B, function 8 gives (NOT A) AND B, and function 9 gives A OR B.
- R9: all_ones is high exactly when the registered result is all ones, and all_zeros is high exactly when it is all zeros.
- R10: The result and flags load only on a clock where in_valid is high and are otherwise held; out_valid equals in_valid delayed by one clock.
- R11: After reset, out_valid is 0, the result is 0, all_zeros is 1 and all_ones is 0.
- R12: Lane size code 3 and function codes 10 to 15 give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| opcode | input | 9 | Size, function, signed mode and shift amount |
| out_valid | output | 1 | Registered result is new this cycle |
| result | output | 64 | Registered packed result |
| all_ones | output | 1 | Result is all ones |
| all_zeros | output | 1 | Result is all zeros |

## Verification
The hardest situations to reach are the saturation boundaries. These are lanes that overflow by exactly one and lanes whose neighbours sit right at the opposite limit. Uniform random operands seldom land there. The stimulus therefore draws each lane's value from a small set of edge values (0, 1, minimum, maximum, the sign boundary) about half the time. It also drives the documented examples as directed cases. Mixed-lane compares that fill only some lanes, and all-equal inputs that light the all-ones flag, are forced by copying operand A into B for part of the compares.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [3:0] {
    FN_ADD   = 4'd0,
    FN_ADDS  = 4'd1,
    FN_SUB   = 4'd2,
    FN_SUBS  = 4'd3,
    FN_SHADD = 4'd4,
    FN_CMPEQ = 4'd5,
    FN_CMPGT = 4'd6,
    FN_AND   = 4'd7,
    FN_ANDN  = 4'd8,
    FN_OR    = 4'd9
  } fn_e;

  typedef struct packed {
    logic [1:0] shamt;
    logic       sgn;
    logic [3:0] fn;
    logic [1:0] size;
  } op_t;

  localparam int OP_W = $bits(op_t);
  localparam int NUM_SIZES = 3;
endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  logic [3:0]    fn,
  input  logic          sgn,
  input  logic [1:0]    shamt,
  output logic [LW-1:0] r
);
  localparam logic [LW-1:0] UMAX = '1;
  localparam logic [LW-1:0] SMAX = {1'b0, {(LW-1){1'b1}}};
  localparam logic [LW-1:0] SMIN = {1'b1, {(LW-1){1'b0}}};

  logic [LW:0]          sum, dif;
  logic                 s_ovf_add, s_ovf_sub, gt;
  logic signed [LW-1:0] bs;
  logic [LW-1:0]        b_ar, b_sh, add_sat, sub_sat;

  always_comb begin
    sum = {1'b0, a} + {1'b0, b};
    dif = {1'b0, a} - {1'b0, b};
    s_ovf_add = (a[LW-1] == b[LW-1]) && (sum[LW-1] != a[LW-1]);
    s_ovf_sub = (a[LW-1] != b[LW-1]) && (dif[LW-1] != a[LW-1]);
    bs   = b;
    b_ar = bs >>> shamt;
    b_sh = sgn ? b_ar : (b >> shamt);
    gt   = sgn ? ($signed(a) > $signed(b)) : (a > b);

    if (sgn) begin
      add_sat = s_ovf_add ? (a[LW-1] ? SMIN : SMAX) : sum[LW-1:0];
      sub_sat = s_ovf_sub ? (a[LW-1] ? SMIN : SMAX) : dif[LW-1:0];
    end else begin
      add_sat = sum[LW] ? UMAX : sum[LW-1:0];
      sub_sat = dif[LW] ? '0 : dif[LW-1:0];
    end

    case (fn)
      FN_ADD:   r = sum[LW-1:0];
      FN_ADDS:  r = add_sat;
      FN_SUB:   r = dif[LW-1:0];
      FN_SUBS:  r = sub_sat;
      FN_SHADD: r = a + b_sh;
      FN_CMPEQ: r = (a == b) ? UMAX : '0;
      FN_CMPGT: r = gt ? UMAX : '0;
      FN_AND:   r = a & b;
      FN_ANDN:  r = ~a & b;
      FN_OR:    r = a | b;
      default:  r = '0;
    endcase
  end
endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
  import simd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [OP_W-1:0]   opcode,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              all_ones,
  output logic              all_zeros
);
  op_t               op;
  logic [DATA_W-1:0] res_w [NUM_SIZES];
  logic [DATA_W-1:0] res_d;
  logic              ones_d, zeros_d;

  assign op = op_t'(opcode);

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    localparam int LW = 8 << k;
    localparam int NL = DATA_W / LW;
    for (genvar j = 0; j < NL; j++) begin : g_lane
      simd_lane #(.LW(LW)) u_lane (
        .a     (op_a[j*LW +: LW]),
        .b     (op_b[j*LW +: LW]),
        .fn    (op.fn),
        .sgn   (op.sgn),
        .shamt (op.shamt),
        .r     (res_w[k][j*LW +: LW])
      );
    end
  end

  always_comb begin
    case (op.size)
      2'd0:    res_d = res_w[0];
      2'd1:    res_d = res_w[1];
      2'd2:    res_d = res_w[2];
      default: res_d = '0;
    endcase
    ones_d  = &res_d;
    zeros_d = ~|res_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      all_ones  <= 1'b0;
      all_zeros <= 1'b1;
    end else if (in_valid) begin
      result    <= res_d;
      all_ones  <= ones_d;
      all_zeros <= zeros_d;
    end
  end
endmodule

// File: rtl/simd_sat_alu_chk.sv
module simd_sat_alu_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [8:0]        opcode,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              all_ones,
  input logic              all_zeros
);
  AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid)); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(all_ones) && $stable(all_zeros)); // R10
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(all_ones && all_zeros)); // R9
  AST_EQ_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && opcode[5:2] == 4'd5 && opcode[1:0] != 2'd3 && op_a == op_b
    |=> all_ones); // R6
  AST_SUB_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (opcode[5:2] == 4'd2 || opcode[5:2] == 4'd3) && opcode[1:0] != 2'd3
    && op_a == op_b |=> all_zeros); // R2
  AST_RSV_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && opcode[1:0] == 2'd3 |=> all_zeros); // R12
endmodule

bind simd_sat_alu simd_sat_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .opcode(opcode), .out_valid(out_valid), .result(result),
  .all_ones(all_ones), .all_zeros(all_zeros)
);

// File: tb/simd_sat_alu_test.sv
module simd_sat_alu_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [8:0]  opcode = '0;
  logic        out_valid, all_ones, all_zeros;
  logic [63:0] result;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  simd_sat_alu uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .opcode(opcode), .out_valid(out_valid), .result(result),
    .all_ones(all_ones), .all_zeros(all_zeros)
  );

  function automatic logic [8:0] mk(int sz, int fn, bit sg, int sh);
    return {sh[1:0], sg, fn[3:0], sz[1:0]};
  endfunction

  function automatic longint clampv(longint v, longint lo, longint hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b, logic [8:0] op);
    int sz, fn, sh, w, n;
    bit sg;
    longint m, lo, hi, ua, ub, sa, sb, t;
    logic [63:0] r;
    sz = int'(op[1:0]); fn = int'(op[5:2]); sg = op[6]; sh = int'(op[8:7]);
    r = '0;
    if (sz == 3) return '0;
    w = 8 << sz; n = 64 / w;
    m  = (64'sd1 <<< w) - 1;
    lo = sg ? -(64'sd1 <<< (w-1)) : 0;
    hi = sg ? (64'sd1 <<< (w-1)) - 1 : m;
    for (int i = 0; i < n; i++) begin
      ua = longint'((a >> (i*w))) & m;
      ub = longint'((b >> (i*w))) & m;
      sa = ((ua >> (w-1)) & 1) != 0 ? ua - (m + 1) : ua;
      sb = ((ub >> (w-1)) & 1) != 0 ? ub - (m + 1) : ub;
      case (fn)
        0: t = ua + ub;
        1: t = sg ? clampv(sa + sb, lo, hi) : clampv(ua + ub, lo, hi);
        2: t = ua - ub;
        3: t = sg ? clampv(sa - sb, lo, hi) : clampv(ua - ub, lo, hi);
        4: t = ua + (sg ? (sb >>> sh) : (ub >> sh));
        5: t = (ua == ub) ? m : 0;
        6: t = (sg ? (sa > sb) : (ua > ub)) ? m : 0;
        7: t = ua & ub;
        8: t = (~ua) & ub;
        9: t = ua | ub;
        default: t = 0;
      endcase
      r = r | (64'(t & m) << (i*w));
    end
    return r;
  endfunction

  function automatic string tag_of(logic [8:0] op);
    if (op[1:0] == 2'd3 || op[5:2] > 4'd9) return "R12";
    case (op[5:2])
      4'd0, 4'd2: return "R2";
      4'd1, 4'd3: return op[6] ? "R4" : "R3";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(logic [63:0] a, logic [63:0] b, logic [8:0] op);
    logic [63:0] e;
    @(negedge clk);
    op_a = a; op_b = b; opcode = op; in_valid = 1'b1;
    e = model(a, b, op);
    @(negedge clk);
    chk(result == e, tag_of(op), result, e);
    chk(all_ones == (&e) && all_zeros == (~|e), "R9",
        {62'd0, all_ones, all_zeros}, {62'd0, &e, ~|e});
    chk(out_valid == 1'b1, "R10", {63'd0, out_valid}, 64'd1);
  endtask

  function automatic logic [63:0] edgy(int sz);
    logic [63:0] v;
    int w;
    w = 8 << sz;
    v = {$urandom, $urandom};
    for (int i = 0; i < 64 / w; i++) begin
      if ($urandom_range(1, 0) == 1) begin
        logic [31:0] e;
        case ($urandom_range(4, 0))
          0: e = 32'd0;
          1: e = 32'd1;
          2: e = 32'hFFFF_FFFF;
          3: e = 32'h7FFF_FFFF >> (32 - w);
          default: e = 32'h1 << (w - 1);
        endcase
        for (int k = 0; k < w; k++) v[i*w + k] = e[k];
      end
    end
    return v;
  endfunction

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(out_valid == 0 && result == 0 && all_zeros == 1 && all_ones == 0, "R11",
        {result[60:0], out_valid, all_ones, all_zeros}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 wrap add on 16-bit lanes: 0x1A00 + 0xF700 = 0x1100
    run_op(64'h1A00_2A00_3A00_4A00, 64'hF700_F700_F700_F700, mk(1, 0, 0, 0));
    chk(result == 64'h1100_2100_3100_4100, "R2", result, 64'h1100_2100_3100_4100);
    // R3 unsigned saturating add clamps to 0xFFFF
    run_op(64'h1A00_2A00_3A00_4A00, 64'hF700_F700_F700_F700, mk(1, 1, 0, 0));
    chk(result == 64'hFFFF_FFFF_FFFF_FFFF, "R3", result, '1);
    // R3 unsigned saturating subtract, 8-bit lanes: 40-51=0, 5-34=0, 78-15=63, 200-243=0
    run_op({32'd0, 8'd40, 8'd5, 8'd78, 8'd200}, {32'd0, 8'd51, 8'd34, 8'd15, 8'd243}, mk(0, 3, 0, 0));
    chk(result == {32'd0, 8'd0, 8'd0, 8'd63, 8'd0}, "R3", result, {32'd0, 8'd0, 8'd0, 8'd63, 8'd0});
    // R4 signed saturation limits on each lane size
    run_op(64'h7F80_7F80_7F80_7F80, 64'h01FF_01FF_01FF_01FF, mk(0, 1, 1, 0));
    chk(result == 64'h7F80_7F80_7F80_7F80, "R4", result, 64'h7F80_7F80_7F80_7F80);
    run_op(64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF, mk(2, 3, 1, 0));
    chk(result == 64'h8000_0000_7FFF_FFFF, "R4", result, 64'h8000_0000_7FFF_FFFF);
    // R5 shift-add with arithmetic shift by 3
    run_op(64'h0010_0010_0010_0010, 64'h8000_0040_8000_0040, mk(1, 4, 1, 3));
    chk(result == 64'hF010_0018_F010_0018, "R5", result, 64'hF010_0018_F010_0018);
    // R6 equality mask on mixed lanes
    run_op(64'h11_22_33_44_55_66_77_88, 64'h11_00_33_00_55_00_77_00, mk(0, 5, 0, 0));
    chk(result == 64'hFF00_FF00_FF00_FF00, "R6", result, 64'hFF00_FF00_FF00_FF00);
    // R7 signed versus unsigned greater-than
    run_op(64'h8000_0000_0000_0001, 64'h0000_0001_0000_0000, mk(2, 6, 0, 0));
    chk(result == 64'hFFFF_FFFF_FFFF_FFFF, "R7", result, '1);
    run_op(64'h8000_0000_0000_0001, 64'h0000_0001_0000_0000, mk(2, 6, 1, 0));
    chk(result == 64'h0000_0000_FFFF_FFFF, "R7", result, 64'h0000_0000_FFFF_FFFF);
    // R8 mask-based select pieces
    run_op(64'hFFFF_0000_FFFF_0000, 64'h1234_5678_9ABC_DEF0, mk(1, 8, 0, 0));
    chk(result == 64'h0000_5678_0000_DEF0, "R8", result, 64'h0000_5678_0000_DEF0);
    // R12 reserved size and function
    run_op('1, '1, mk(3, 0, 0, 0));
    run_op('1, 64'd5, mk(0, 12, 0, 0));
    // R10 hold while idle
    run_op(64'h0123_4567_89AB_CDEF, 64'h1, mk(0, 9, 0, 0));
    held = result;
    @(negedge clk);
    in_valid = 1'b0; op_a = '0; op_b = '0; opcode = mk(0, 0, 0, 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R10", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    chk(result == held && all_zeros == 1'b0, "R10", result, held);

    // Random mix with edge-biased lanes
    for (int n = 0; n < 600; n++) begin
      int sz, fn;
      logic [63:0] a, b;
      sz = $urandom_range(2, 0);
      fn = $urandom_range(9, 0);
      a = edgy(sz);
      b = ((fn == 5 || fn == 6) && $urandom_range(3, 0) == 0) ? a : edgy(sz);
      run_op(a, b, mk(sz, fn, $urandom_range(1, 0) == 1, $urandom_range(3, 0)));
    end
    @(negedge clk);
    in_valid = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule